// File: doc/BRIEF.md
# Multi-Endpoint Processor Buffer Port

This block is the slave side of a memory-mapped link between an external processor and a set of internal endpoint data buffers. The processor sees a small synchronous SRAM-style window. Low addresses reach control and status registers. A second group of addresses reaches one data port per endpoint. Each endpoint buffer is a FIFO with a fixed direction. An OUT buffer is filled by the internal side and drained by the processor. An IN buffer is filled by the processor and drained by the internal side.

The block tells the processor that a buffer needs service in one of two ways, and the processor selects which one. In DMA mode a level request line stays high while any buffer is ready. In interrupt mode the request line stays low. Instead, an interrupt line is raised from sticky status events that pass through a per-bit mask. In both modes the processor finds out which buffers need attention by reading the ready and status registers. It then moves whole buffers through the data ports.

With the default parameters there are 4 endpoints. Each holds 64 bytes, which is 32 words of 16 bits. Endpoints 0 and 1 are OUT and endpoints 2 and 3 are IN.

Top module: `pbi_host_port`

## Requirements
- R1: After reset the mode is DMA (0), the mask and status registers are 0, the ready flags equal the IN-direction bits (0x000C by default), every fill count is 0, irq is 0, dma_req is 1 when any endpoint is IN, and bus_rdata is 0.
- R2: Address map (5-bit word address). 0x00 is the config register: bit 0 selects the mode (0 = DMA, 1 = interrupt) and bits 11:8 are the read-only direction bits, where 1 means IN. 0x01 is the mask register, 8 bits. 0x02 is the status register. 0x03 holds the ready flags in bits 3:0. 0x04+i is the fill count of endpoint i. 0x10+i is the data port of endpoint i. All other addresses read 0 and ignore writes.
- R3: A read (bus_cs=1, bus_oe=1, bus_we=0) returns its data on bus_rdata in the cycle after the access. In every other cycle bus_rdata is 0.
- R4: Each buffer is first-in first-out. Words the internal side pushes into an OUT buffer come out of its data port in order. Words the processor writes to an IN buffer appear in order on int_rd_data, which shows the head of the IN endpoint selected by int_rd_ep without a clock; int_rd_en pops that head.
- R5: The ready flag of an OUT endpoint sets when its buffer reaches 32 words. It stays set until processor reads empty the buffer.
- R6: The ready flag of an IN endpoint is set at reset and sets again when internal pops empty the buffer. It clears when processor writes fill the buffer to 32 words.
- R7: Status bit i (bits 3:0) sets when ready flag i rises. Status bit 4+i sets when the processor reads an empty OUT data port; that read returns 0. Writing 1 to a status bit clears it. A set in the same cycle as a clear wins.
- R8: In interrupt mode, irq is high exactly while some status bit and its mask bit are both 1. It updates at the edge that changes status, mask or mode, so it falls in the cycle after the clearing write. In DMA mode, irq is 0.
- R9: In DMA mode, dma_req is high while any ready flag is set. In interrupt mode, dma_req is 0.
- R10: These accesses change no count, status or data: a processor write to an OUT data port, a processor read of an IN data port (returns 0), a processor write to a full IN buffer, an internal push to an IN endpoint or to a full OUT buffer, and an internal pop of an OUT endpoint or of an empty IN buffer. int_rd_data is 0 when the selected endpoint is OUT or empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Processor bus chip select |
| bus_we | input | 1 | Processor write enable |
| bus_oe | input | 1 | Processor output (read) enable |
| bus_addr | input | 5 | Processor word address |
| bus_wdata | input | 16 | Processor write data |
| bus_rdata | output | 16 | Registered read data |
| dma_req | output | 1 | Level buffer-service request (DMA mode) |
| irq | output | 1 | Masked status interrupt (interrupt mode) |
| int_wr_en | input | 1 | Internal push into an OUT endpoint |
| int_wr_ep | input | 2 | Endpoint selected for the internal push |
| int_wr_data | input | 16 | Word pushed by the internal side |
| int_rd_en | input | 1 | Internal pop from an IN endpoint |
| int_rd_ep | input | 2 | Endpoint selected for the internal pop and head view |
| int_rd_data | output | 16 | Head word of the selected IN endpoint |

## Verification
The checker assumes one processor access per cycle, carried by a single-cycle strobe. When bus_we is high the access is a write, whatever bus_oe is. It also assumes the processor changes irq only through a write to the config, mask or status register. This is what lets a falling irq be traced back to such a write. The bench drives every input at the falling clock edge, holds each access for exactly one cycle, and never asserts bus_we and bus_oe together. This keeps the stimulus inside these assumptions. Mixed cycles, such as a status clear that lands in the same cycle as an internal push, are built as one explicit cycle.

// File: rtl/pbi_pkg.sv
package pbi_pkg;

    // Register slots within the low address window.
    typedef enum logic [3:0] {
        RIX_CFG   = 4'd0,
        RIX_MASK  = 4'd1,
        RIX_STAT  = 4'd2,
        RIX_READY = 4'd3,
        RIX_FILL0 = 4'd4
    } pbi_reg_e;

    // First word address of the endpoint data ports.
    localparam int DATA_BASE = 16;

    // Bit position of the direction field in the config word.
    localparam int DIR_LSB = 8;

endpackage

// File: rtl/pbi_decode.sv
module pbi_decode #(
    parameter int AW  = 5,
    parameter int NEP = 4
) (
    input  logic           cs,
    input  logic           we,
    input  logic           oe,
    input  logic [AW-1:0]  addr,
    output logic           acc_wr,
    output logic           acc_rd,
    output logic           reg_hit,
    output logic [3:0]     reg_idx,
    output logic [NEP-1:0] ep_hit
);
    import pbi_pkg::*;

    always_comb begin
        acc_wr  = cs && we;
        acc_rd  = cs && oe && !we;
        reg_hit = (addr < AW'(DATA_BASE));
        reg_idx = addr[3:0];
        for (int i = 0; i < NEP; i++) begin
            ep_hit[i] = (addr == AW'(DATA_BASE + i));
        end
    end

endmodule

// File: rtl/pbi_fifo.sv
module pbi_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    parameter int CNT_W = 6,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    head,
    output logic [CNT_W-1:0] fill
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        ptr_d   = ptr_q;
        do_push = push && (ptr_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (ptr_q.cnt != '0);
        if (do_push) begin
            ptr_d.wp = (ptr_q.wp == PTR_W'(DEPTH - 1)) ? '0 : ptr_q.wp + 1'b1;
        end
        if (do_pop) begin
            ptr_d.rp = (ptr_q.rp == PTR_W'(DEPTH - 1)) ? '0 : ptr_q.rp + 1'b1;
        end
        ptr_d.cnt = ptr_q.cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[ptr_q.wp] <= wdata;
        end
    end

    assign head = mem[ptr_q.rp];
    assign fill = ptr_q.cnt;

endmodule

// File: rtl/pbi_regs.sv
module pbi_regs #(
    parameter int             NEP      = 4,
    parameter int             DW       = 16,
    parameter int             DEPTH    = 32,
    parameter int             CNT_W    = 6,
    parameter logic [NEP-1:0] EP_IS_IN = 4'b1100,
    localparam int            SW       = 2 * NEP
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_wr,
    input  logic                      acc_rd,
    input  logic                      reg_hit,
    input  logic [3:0]                reg_idx,
    input  logic [NEP-1:0]            ep_hit,
    input  logic [SW-1:0]             ctl_wdata,
    input  logic [NEP-1:0][CNT_W-1:0] fill,
    input  logic [NEP-1:0][DW-1:0]    head,
    input  logic [NEP-1:0]            int_push,
    input  logic [NEP-1:0]            int_pop,
    output logic [NEP-1:0]            proc_push,
    output logic [NEP-1:0]            proc_pop,
    output logic [DW-1:0]             rdata,
    output logic                      irq,
    output logic                      dma_req,
    output logic                      irq_mode,
    output logic [SW-1:0]             status,
    output logic [NEP-1:0]            ready
);
    import pbi_pkg::*;

    typedef struct packed {
        logic           mode;
        logic [SW-1:0]  mask;
        logic [SW-1:0]  status;
        logic [NEP-1:0] ready;
        logic [DW-1:0]  rdata;
        logic           irq;
        logic           dreq;
    } regs_t;

    localparam regs_t RST_VAL = '{
        mode:   1'b0,
        mask:   '0,
        status: '0,
        ready:  EP_IS_IN,
        rdata:  '0,
        irq:    1'b0,
        dreq:   |EP_IS_IN
    };

    regs_t regs_d, regs_q;

    logic [NEP-1:0][CNT_W-1:0] fill_nx;
    logic [NEP-1:0]            full_now;
    logic [NEP-1:0]            empty_now;
    logic [NEP-1:0]            rise;
    logic [NEP-1:0]            uflow;
    logic [DW-1:0]             cfg_word;

    assign cfg_word = DW'(regs_q.mode) | (DW'(EP_IS_IN) << DIR_LSB);

    always_comb begin
        regs_d       = regs_q;
        regs_d.rdata = '0;

        // Buffer-side moves, fill prediction and ready hysteresis.
        for (int i = 0; i < NEP; i++) begin
            full_now[i]  = (fill[i] == CNT_W'(DEPTH));
            empty_now[i] = (fill[i] == '0);
            proc_push[i] = acc_wr && ep_hit[i] && EP_IS_IN[i] && !full_now[i];
            proc_pop[i]  = acc_rd && ep_hit[i] && !EP_IS_IN[i] && !empty_now[i];
            uflow[i]     = acc_rd && ep_hit[i] && !EP_IS_IN[i] && empty_now[i];
            fill_nx[i]   = fill[i]
                         + CNT_W'(proc_push[i] | int_push[i])
                         - CNT_W'(proc_pop[i] | int_pop[i]);
            if (EP_IS_IN[i]) begin
                regs_d.ready[i] = regs_q.ready[i] ? (fill_nx[i] != CNT_W'(DEPTH))
                                                  : (fill_nx[i] == '0);
            end else begin
                regs_d.ready[i] = regs_q.ready[i] ? (fill_nx[i] != '0)
                                                  : (fill_nx[i] == CNT_W'(DEPTH));
            end
            rise[i] = regs_d.ready[i] && !regs_q.ready[i];
        end

        // Register writes.
        if (acc_wr && reg_hit) begin
            if (reg_idx == RIX_CFG) begin
                regs_d.mode = ctl_wdata[0];
            end
            if (reg_idx == RIX_MASK) begin
                regs_d.mask = ctl_wdata;
            end
            if (reg_idx == RIX_STAT) begin
                regs_d.status = regs_q.status & ~ctl_wdata;
            end
        end

        // New events override a clear in the same cycle.
        regs_d.status = regs_d.status | {uflow, rise};

        // Read data for the next cycle.
        if (acc_rd) begin
            if (reg_hit) begin
                if (reg_idx == RIX_CFG) begin
                    regs_d.rdata = cfg_word;
                end
                if (reg_idx == RIX_MASK) begin
                    regs_d.rdata = DW'(regs_q.mask);
                end
                if (reg_idx == RIX_STAT) begin
                    regs_d.rdata = DW'(regs_q.status);
                end
                if (reg_idx == RIX_READY) begin
                    regs_d.rdata = DW'(regs_q.ready);
                end
                for (int j = 0; j < NEP; j++) begin
                    if (reg_idx == 4'(RIX_FILL0 + j)) begin
                        regs_d.rdata = DW'(fill[j]);
                    end
                end
            end else begin
                for (int i = 0; i < NEP; i++) begin
                    if (proc_pop[i]) begin
                        regs_d.rdata = head[i];
                    end
                end
            end
        end

        regs_d.irq  = regs_d.mode && |(regs_d.status & regs_d.mask);
        regs_d.dreq = !regs_d.mode && |regs_d.ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= RST_VAL;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata    = regs_q.rdata;
    assign irq      = regs_q.irq;
    assign dma_req  = regs_q.dreq;
    assign irq_mode = regs_q.mode;
    assign status   = regs_q.status;
    assign ready    = regs_q.ready;

endmodule

// File: rtl/pbi_host_port.sv
module pbi_host_port #(
    parameter int                 NUM_EP    = 4,
    parameter int                 DATA_W    = 16,
    parameter int                 BUF_BYTES = 64,
    parameter int                 ADDR_W    = 5,
    parameter logic [NUM_EP-1:0]  EP_IS_IN  = 4'b1100,
    localparam int                DEPTH     = BUF_BYTES / (DATA_W / 8),
    localparam int                CNT_W     = $clog2(DEPTH + 1),
    localparam int                EP_W      = $clog2(NUM_EP),
    localparam int                SW        = 2 * NUM_EP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic              bus_oe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dma_req,
    output logic              irq,
    input  logic              int_wr_en,
    input  logic [EP_W-1:0]   int_wr_ep,
    input  logic [DATA_W-1:0] int_wr_data,
    input  logic              int_rd_en,
    input  logic [EP_W-1:0]   int_rd_ep,
    output logic [DATA_W-1:0] int_rd_data
);
    logic                         acc_wr, acc_rd, reg_hit;
    logic [3:0]                   reg_idx;
    logic [NUM_EP-1:0]            ep_hit;
    logic [NUM_EP-1:0]            proc_push, proc_pop;
    logic [NUM_EP-1:0]            int_push, int_pop;
    logic [NUM_EP-1:0][CNT_W-1:0] fill;
    logic [NUM_EP-1:0][DATA_W-1:0] head;
    logic                         mode_w;
    logic [SW-1:0]                status_w;
    logic [NUM_EP-1:0]            ready_w;

    pbi_decode #(
        .AW  (ADDR_W),
        .NEP (NUM_EP)
    ) u_decode (
        .cs      (bus_cs),
        .we      (bus_we),
        .oe      (bus_oe),
        .addr    (bus_addr),
        .acc_wr  (acc_wr),
        .acc_rd  (acc_rd),
        .reg_hit (reg_hit),
        .reg_idx (reg_idx),
        .ep_hit  (ep_hit)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        assign int_push[g] = int_wr_en && (int_wr_ep == EP_W'(g)) && !EP_IS_IN[g]
                          && (fill[g] != CNT_W'(DEPTH));
        assign int_pop[g]  = int_rd_en && (int_rd_ep == EP_W'(g)) && EP_IS_IN[g]
                          && (fill[g] != '0);

        pbi_fifo #(
            .DW    (DATA_W),
            .DEPTH (DEPTH),
            .CNT_W (CNT_W)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (proc_push[g] | int_push[g]),
            .wdata (EP_IS_IN[g] ? bus_wdata : int_wr_data),
            .pop   (proc_pop[g] | int_pop[g]),
            .head  (head[g]),
            .fill  (fill[g])
        );
    end

    pbi_regs #(
        .NEP      (NUM_EP),
        .DW       (DATA_W),
        .DEPTH    (DEPTH),
        .CNT_W    (CNT_W),
        .EP_IS_IN (EP_IS_IN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .reg_hit   (reg_hit),
        .reg_idx   (reg_idx),
        .ep_hit    (ep_hit),
        .ctl_wdata (bus_wdata[SW-1:0]),
        .fill      (fill),
        .head      (head),
        .int_push  (int_push),
        .int_pop   (int_pop),
        .proc_push (proc_push),
        .proc_pop  (proc_pop),
        .rdata     (bus_rdata),
        .irq       (irq),
        .dma_req   (dma_req),
        .irq_mode  (mode_w),
        .status    (status_w),
        .ready     (ready_w)
    );

    assign int_rd_data = (EP_IS_IN[int_rd_ep] && (fill[int_rd_ep] != '0))
                       ? head[int_rd_ep] : '0;

endmodule

// File: rtl/pbi_host_port_chk.sv
module pbi_host_port_chk #(
    parameter int NEP = 4,
    parameter int AW  = 5,
    parameter int DW  = 16,
    localparam int SW = 2 * NEP
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_cs,
    input logic           bus_we,
    input logic           bus_oe,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_rdata,
    input logic           irq,
    input logic           dma_req,
    input logic           irq_mode,
    input logic [SW-1:0]  status,
    input logic [NEP-1:0] ready
);

    // R9
    dreq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mode |-> !dma_req);

    // R9
    dreq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mode |-> (dma_req == (ready != '0)));

    // R8
    irq_dma_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mode |-> !irq);

    // R8
    irq_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_cs && bus_we && (bus_addr < AW'(3))));

    // R3
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_oe && !bus_we) |=> (bus_rdata == '0));

    // R7
    uflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status[SW-1:NEP] & ~$past(status[SW-1:NEP])) != '0)
        |-> $past(bus_cs && bus_oe && !bus_we && (bus_addr >= AW'(16))));

endmodule

bind pbi_host_port pbi_host_port_chk #(
    .NEP (NUM_EP),
    .AW  (ADDR_W),
    .DW  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_we    (bus_we),
    .bus_oe    (bus_oe),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .dma_req   (dma_req),
    .irq_mode  (mode_w),
    .status    (status_w),
    .ready     (ready_w)
);

// File: tb/pbi_host_port_bench.sv
`timescale 1ns/1ps
module pbi_host_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_we = 1'b0, bus_oe = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        dma_req, irq;
    logic        int_wr_en = 1'b0;
    logic [1:0]  int_wr_ep = '0;
    logic [15:0] int_wr_data = '0;
    logic        int_rd_en = 1'b0;
    logic [1:0]  int_rd_ep = '0;
    logic [15:0] int_rd_data;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    pbi_host_port u_pbi_host_port (
        .clk(clk), .rst_n(rst_n),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_req(dma_req), .irq(irq),
        .int_wr_en(int_wr_en), .int_wr_ep(int_wr_ep), .int_wr_data(int_wr_data),
        .int_rd_en(int_rd_en), .int_rd_ep(int_rd_ep), .int_rd_data(int_rd_data)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Driver: one bus write cycle.
    task automatic bus_wr(logic [4:0] a, logic [15:0] d);
        bus_cs = 1'b1; bus_we = 1'b1; bus_oe = 1'b0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    // Driver: one bus read cycle, expected value pushed to the scoreboard.
    task automatic bus_rd(logic [4:0] a, logic [15:0] e, string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_cs = 1'b1; bus_we = 1'b0; bus_oe = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_cs = 1'b0; bus_oe = 1'b0;
    endtask

    task automatic ipush(logic [1:0] ep, logic [15:0] d);
        int_wr_en = 1'b1; int_wr_ep = ep; int_wr_data = d;
        @(negedge clk);
        int_wr_en = 1'b0;
    endtask

    task automatic ipop(logic [1:0] ep);
        int_rd_en = 1'b1; int_rd_ep = ep;
        @(negedge clk);
        int_rd_en = 1'b0;
    endtask

    // Monitor: compares each registered read result with the scoreboard.
    always @(posedge clk) rd_seen <= rst_n && bus_cs && bus_oe && !bus_we;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R3 unexpected read result actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 dma_req", {15'd0, dma_req}, 16'd1);
        chk("R1 rdata", bus_rdata, 16'd0);
        bus_rd(5'h00, 16'h0C00, "R2 cfg reset");
        bus_rd(5'h01, 16'h0000, "R1 mask reset");
        bus_rd(5'h02, 16'h0000, "R1 status reset");
        bus_rd(5'h03, 16'h000C, "R1 ready reset");
        bus_rd(5'h04, 16'h0000, "R1 fill0 reset");
        bus_rd(5'h09, 16'h0000, "R2 unmapped reg");
        bus_rd(5'h17, 16'h0000, "R2 unmapped port");

        // R10 ignored accesses
        bus_wr(5'h10, 16'h1234);
        bus_rd(5'h04, 16'h0000, "R10 write to OUT port");
        bus_rd(5'h12, 16'h0000, "R10 read of IN port");
        bus_rd(5'h02, 16'h0000, "R10 no underflow from IN read");
        ipush(2'd2, 16'h5555);
        bus_rd(5'h06, 16'h0000, "R10 internal push to IN");
        int_rd_ep = 2'd0; #1;
        chk("R10 int_rd_data on OUT", int_rd_data, 16'h0000);
        bus_wr(5'h15, 16'hFFFF);
        bus_rd(5'h00, 16'h0C00, "R2 unmapped write cfg");
        bus_rd(5'h01, 16'h0000, "R2 unmapped write mask");

        // R7 underflow
        bus_rd(5'h10, 16'h0000, "R7 empty read data");
        bus_rd(5'h02, 16'h0010, "R7 underflow bit");

        // Mode and mask, R8 R9
        bus_wr(5'h00, 16'h0001);
        chk("R9 dma_req in irq mode", {15'd0, dma_req}, 16'd0);
        chk("R8 irq masked", {15'd0, irq}, 16'd0);
        bus_wr(5'h01, 16'h00FF);
        chk("R8 irq unmasked", {15'd0, irq}, 16'd1);
        bus_rd(5'h00, 16'h0C01, "R2 cfg mode bit");
        bus_wr(5'h02, 16'h0010);
        chk("R8 irq after clear", {15'd0, irq}, 16'd0);
        bus_rd(5'h02, 16'h0000, "R7 w1c");

        // OUT fill, R5
        for (int i = 0; i < 31; i++) ipush(2'd0, 16'hA000 + 16'(i));
        chk("R5 no irq before full", {15'd0, irq}, 16'd0);
        bus_rd(5'h03, 16'h000C, "R5 not ready at 31");
        ipush(2'd0, 16'hA01F);
        chk("R8 irq on ready rise", {15'd0, irq}, 16'd1);
        bus_rd(5'h03, 16'h000D, "R5 ready at full");
        bus_rd(5'h02, 16'h0001, "R7 ready event");
        bus_rd(5'h04, 16'd32, "R5 fill full");
        ipush(2'd0, 16'hFFFF);
        bus_rd(5'h04, 16'd32, "R10 push to full OUT");

        // OUT drain, R4 R5
        for (int i = 0; i < 16; i++) bus_rd(5'h10, 16'hA000 + 16'(i), "R4 OUT order");
        bus_rd(5'h03, 16'h000D, "R5 ready holds");
        for (int i = 16; i < 32; i++) bus_rd(5'h10, 16'hA000 + 16'(i), "R4 OUT order");
        bus_rd(5'h03, 16'h000C, "R5 ready clears empty");
        bus_rd(5'h04, 16'h0000, "R5 fill empty");
        bus_wr(5'h02, 16'hFFFF);
        chk("R8 irq cleared", {15'd0, irq}, 16'd0);

        // Mask gating, R8
        bus_wr(5'h01, 16'h0000);
        bus_rd(5'h11, 16'h0000, "R7 empty read ep1");
        chk("R8 masked event", {15'd0, irq}, 16'd0);
        bus_rd(5'h02, 16'h0020, "R7 underflow ep1");
        bus_wr(5'h01, 16'h0020);
        chk("R8 unmask raises", {15'd0, irq}, 16'd1);
        bus_wr(5'h02, 16'h0020);
        chk("R8 clear lowers", {15'd0, irq}, 16'd0);

        // IN path, R6 R4
        for (int i = 0; i < 31; i++) bus_wr(5'h13, 16'hB000 + 16'(i));
        bus_rd(5'h03, 16'h000C, "R6 ready at 31");
        bus_wr(5'h13, 16'hB01F);
        bus_rd(5'h03, 16'h0004, "R6 ready clears full");
        bus_wr(5'h13, 16'hDEAD);
        bus_rd(5'h07, 16'd32, "R10 write to full IN");
        bus_rd(5'h02, 16'h0000, "R7 no event on fall");
        for (int i = 0; i < 32; i++) begin
            int_rd_ep = 2'd3; #1;
            chk("R4 IN order", int_rd_data, 16'hB000 + 16'(i));
            ipop(2'd3);
        end
        bus_rd(5'h03, 16'h000C, "R6 ready on empty");
        bus_rd(5'h02, 16'h0008, "R7 IN ready event");
        chk("R8 event masked", {15'd0, irq}, 16'd0);
        int_rd_ep = 2'd3; #1;
        chk("R10 int_rd_data empty", int_rd_data, 16'h0000);
        ipop(2'd3);
        bus_rd(5'h07, 16'h0000, "R10 pop of empty IN");

        // DMA mode, R8 R9
        bus_wr(5'h01, 16'h00FF);
        chk("R8 irq pending", {15'd0, irq}, 16'd1);
        bus_wr(5'h00, 16'h0000);
        chk("R8 irq low in DMA", {15'd0, irq}, 16'd0);
        chk("R9 dma_req ready", {15'd0, dma_req}, 16'd1);
        for (int i = 0; i < 32; i++) bus_wr(5'h12, 16'(i));
        for (int i = 0; i < 32; i++) bus_wr(5'h13, 16'(i));
        chk("R9 dma_req none ready", {15'd0, dma_req}, 16'd0);
        bus_rd(5'h03, 16'h0000, "R9 ready all clear");
        for (int i = 0; i < 32; i++) ipop(2'd2);
        chk("R9 dma_req after drain", {15'd0, dma_req}, 16'd1);

        // Set wins over clear, R7
        bus_wr(5'h02, 16'hFFFF);
        for (int i = 0; i < 31; i++) ipush(2'd1, 16'(i));
        int_wr_en = 1'b1; int_wr_ep = 2'd1; int_wr_data = 16'h0031;
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 5'h02; bus_wdata = 16'h0002;
        @(negedge clk);
        int_wr_en = 1'b0; bus_cs = 1'b0; bus_we = 1'b0;
        bus_rd(5'h02, 16'h0002, "R7 set wins");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R3 missing reads actual=%0d expected=0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule